// File: doc/BRIEF.md
# 4-bit Accumulator Execution Unit

This block is the data path of a small 4-bit controller. Each clock it can accept one decoded instruction together with a 4-bit immediate field and the 4-bit operand read from data memory. It updates an accumulator and a carry flag, and it can ask the instruction sequencer to discard the next instruction. Skip decisions belong to the arithmetic itself: an immediate add that does not overflow skips, a carry test skips on a clear carry, and in a run of immediate loads only the first one takes effect.

A second 4-bit operand register and a logic-select register feed a combined XOR/OR/AND instruction. Both are loaded through their own write strobes. The unit also discards the instruction that follows a skip request by itself, so the sequencer only has to drop the matching fetch. Instruction fetch, the program counter, memory addressing and raw opcode decoding live elsewhere.

Top module: `acc4_exec_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the accumulator, carry, E register, LO register, pending skip and load-run flag are cleared, so `acc`=0, `carry`=0 and `skip_req`=0 after that edge.
- R2: An executed load-immediate (opcode 4'd1) writes `imm` into the accumulator. Carry is not changed. The load-run flag is set.
- R3: A load-immediate presented while the load-run flag is set leaves accumulator and carry unchanged. The flag is set by any accepted load-immediate, whether executed or discarded. It is cleared by any other accepted opcode. Idle cycles (`op_valid`=0) do not touch it.
- R4: Add-memory (opcode 4'd2) writes `acc + mem_data` modulo 16 to the accumulator and leaves carry unchanged.
- R5: Add-memory-with-carry (opcode 4'd3) writes `acc + mem_data + carry` modulo 16 to the accumulator and writes the carry out of bit 3 to carry.
- R6: Add-immediate (opcode 4'd4) writes `acc + imm` modulo 16 to the accumulator and leaves carry unchanged. It raises a skip request exactly when the sum does not carry out of bit 3.
- R7: Set-carry (opcode 4'd5) makes carry 1. Clear-carry (opcode 4'd6) makes carry 0. The accumulator is unchanged.
- R8: Skip-if-carry-zero (opcode 4'd7) raises a skip request when carry is 0 and changes neither accumulator nor carry.
- R9: Complement (opcode 4'd8) replaces the accumulator with its bitwise inverse.
- R10: Rotate-right (opcode 4'd9) moves the old carry into bit 3 and the old bit 0 into carry, and shifts bits 3..1 down by one place.
- R11: Logic-op (opcode 4'd10) writes `acc op E` to the accumulator. The operation comes from LO: 2'b00 XOR, 2'b01 OR, 2'b10 AND, 2'b11 AND. Carry is unchanged.
- R12: `e_wr` loads `e_data` into E and `lo_wr` loads `lo_data` into LO at the rising edge. These writes take place whether or not an instruction is being discarded. A logic-op in the same cycle uses the old values.
- R13: `skip_req` rises at the edge that completes a skip-requesting instruction. It stays high through idle cycles. The next accepted instruction is then discarded (no change to accumulator or carry, no skip request of its own), and `skip_req` falls at that edge.
- R14: Opcodes 4'd0 and 4'd11 to 4'd15 change neither accumulator nor carry and raise no skip request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An instruction is presented this cycle |
| op_code | input | 4 | Decoded operation code |
| imm | input | 4 | Immediate field of the instruction |
| mem_data | input | 4 | Data-memory operand |
| e_wr | input | 1 | Write strobe for the E register |
| e_data | input | 4 | Value for the E register |
| lo_wr | input | 1 | Write strobe for the logic-select register |
| lo_data | input | 2 | Value for the logic-select register |
| acc | output | 4 | Accumulator |
| carry | output | 1 | Carry flag |
| skip_req | output | 1 | Asks the sequencer to drop the next instruction |

## Verification
The assertions assume that `op_code` and the operand inputs are at known values whenever `op_valid` is high. They also assume that the sequencer keeps offering instructions after a skip, so the discarded one is the next accepted opcode and not a fetch the unit never sees. The stimulus drives every input from defined values at the falling edge and mixes idle cycles in among instructions. It weights load-immediate and add-immediate heavily so that load runs, runs broken by idle cycles, and skip chains appear often.

// File: rtl/acc4_pkg.sv
// Package: shared operation codes for the accumulator execution unit.
// Assumes the decoder upstream delivers these 4-bit codes unchanged.
package acc4_pkg;

    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_NOP  = 4'd0,
        OP_LDI  = 4'd1,
        OP_ADDM = 4'd2,
        OP_ADCM = 4'd3,
        OP_ADDI = 4'd4,
        OP_SETC = 4'd5,
        OP_CLRC = 4'd6,
        OP_TSTC = 4'd7,
        OP_INV  = 4'd8,
        OP_ROR  = 4'd9,
        OP_LOGX = 4'd10
    } op_e;

    typedef enum logic [1:0] {
        LG_XOR = 2'b00,
        LG_OR  = 2'b01,
        LG_AND = 2'b10,
        LG_AN2 = 2'b11
    } logic_sel_e;

endpackage

// File: rtl/acc4_alu.sv
// Module: acc4_alu
// Pure combinational next-state logic for accumulator and carry, plus the
// skip condition the instruction would raise if executed.
// Assumes the caller decides whether the result is committed.
module acc4_alu
    import acc4_pkg::*;
#(
    parameter int DW  = 4,
    parameter int LSW = 2
) (
    input  logic [OPW-1:0] op_code,
    input  logic [DW-1:0]  acc_q,
    input  logic           cy_q,
    input  logic [DW-1:0]  imm,
    input  logic [DW-1:0]  mem_data,
    input  logic [DW-1:0]  e_q,
    input  logic [LSW-1:0] lo_q,
    output logic [DW-1:0]  acc_nx,
    output logic           cy_nx,
    output logic           skip_nx
);

    localparam int SW = DW + 1;

    logic [SW-1:0] sum_mem;
    logic [SW-1:0] sum_memc;
    logic [SW-1:0] sum_imm;
    logic [DW-1:0] logic_res;

    // Adders shared by the three add flavours.
    always_comb begin
        sum_mem  = {1'b0, acc_q} + {1'b0, mem_data};
        sum_memc = {1'b0, acc_q} + {1'b0, mem_data} + {{DW{1'b0}}, cy_q};
        sum_imm  = {1'b0, acc_q} + {1'b0, imm};
    end

    // Logic unit: operation selected by the LO register, top code falls to AND.
    always_comb begin
        unique case (lo_q[1:0])
            LG_XOR:  logic_res = acc_q ^ e_q;
            LG_OR:   logic_res = acc_q | e_q;
            default: logic_res = acc_q & e_q;
        endcase
    end

    // Per-opcode selection of next accumulator, carry and skip condition.
    always_comb begin
        acc_nx  = acc_q;
        cy_nx   = cy_q;
        skip_nx = 1'b0;
        case (op_code)
            OP_LDI:  acc_nx = imm;
            OP_ADDM: acc_nx = sum_mem[DW-1:0];
            OP_ADCM: begin
                acc_nx = sum_memc[DW-1:0];
                cy_nx  = sum_memc[DW];
            end
            OP_ADDI: begin
                acc_nx  = sum_imm[DW-1:0];
                skip_nx = ~sum_imm[DW];
            end
            OP_SETC: cy_nx = 1'b1;
            OP_CLRC: cy_nx = 1'b0;
            OP_TSTC: skip_nx = ~cy_q;
            OP_INV:  acc_nx = ~acc_q;
            OP_ROR: begin
                acc_nx = {cy_q, acc_q[DW-1:1]};
                cy_nx  = acc_q[0];
            end
            OP_LOGX: acc_nx = logic_res;
            default: ;
        endcase
    end

endmodule

// File: rtl/acc4_seq.sv
// Module: acc4_seq
// Skip bookkeeping: holds the pending skip and the load-run flag and
// decides whether the presented instruction is committed.
// Assumes op_valid marks exactly one instruction per asserted cycle.
module acc4_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic op_valid,
    input  logic is_ldi,
    input  logic skip_cond,
    output logic commit,
    output logic skip_q,
    output logic ldi_run_q
);

    logic discard;

    // Discard when a skip is pending or a load follows a load.
    always_comb begin
        discard = skip_q | (is_ldi & ldi_run_q);
        commit  = op_valid & ~discard;
    end

    // Pending skip: set by a committed requester, cleared by any accepted op.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_q <= 1'b0;
        end else if (op_valid) begin
            skip_q <= commit & skip_cond;
        end
    end

    // Load-run flag: tracks whether the last accepted op was a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ldi_run_q <= 1'b0;
        end else if (op_valid) begin
            ldi_run_q <= is_ldi;
        end
    end

endmodule

// File: rtl/acc4_oprnd.sv
// Module: acc4_oprnd
// Second operand register E and logic-select register LO, each with its
// own write strobe. Writes ignore the skip state by design.
module acc4_oprnd #(
    parameter int DW  = 4,
    parameter int LSW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           e_wr,
    input  logic [DW-1:0]  e_data,
    input  logic           lo_wr,
    input  logic [LSW-1:0] lo_data,
    output logic [DW-1:0]  e_q,
    output logic [LSW-1:0] lo_q
);

    // E register load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q <= '0;
        end else if (e_wr) begin
            e_q <= e_data;
        end
    end

    // LO register load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (lo_wr) begin
            lo_q <= lo_data;
        end
    end

endmodule

// File: rtl/acc4_exec_unit.sv
// Module: acc4_exec_unit (top)
// 4-bit accumulator execution unit: ALU, skip control and operand registers.
// Assumes decoded opcodes from acc4_pkg; raw opcode decode is upstream.
module acc4_exec_unit
    import acc4_pkg::*;
#(
    parameter int DW  = 4,
    parameter int LSW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_valid,
    input  logic [3:0]     op_code,
    input  logic [DW-1:0]  imm,
    input  logic [DW-1:0]  mem_data,
    input  logic           e_wr,
    input  logic [DW-1:0]  e_data,
    input  logic           lo_wr,
    input  logic [LSW-1:0] lo_data,
    output logic [DW-1:0]  acc,
    output logic           carry,
    output logic           skip_req
);

    logic [DW-1:0]  acc_q;
    logic           cy_q;
    logic [DW-1:0]  acc_nx;
    logic           cy_nx;
    logic           skip_nx;
    logic [DW-1:0]  e_q;
    logic [LSW-1:0] lo_q;
    logic           commit;
    logic           ldi_run_q;
    logic           is_ldi;

    // Opcode test used by the load-run logic.
    always_comb is_ldi = (op_code == OP_LDI);

    acc4_alu #(.DW(DW), .LSW(LSW)) u_alu (
        .op_code  (op_code),
        .acc_q    (acc_q),
        .cy_q     (cy_q),
        .imm      (imm),
        .mem_data (mem_data),
        .e_q      (e_q),
        .lo_q     (lo_q),
        .acc_nx   (acc_nx),
        .cy_nx    (cy_nx),
        .skip_nx  (skip_nx)
    );

    acc4_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .is_ldi    (is_ldi),
        .skip_cond (skip_nx),
        .commit    (commit),
        .skip_q    (skip_req),
        .ldi_run_q (ldi_run_q)
    );

    acc4_oprnd #(.DW(DW), .LSW(LSW)) u_opr (
        .clk     (clk),
        .rst_n   (rst_n),
        .e_wr    (e_wr),
        .e_data  (e_data),
        .lo_wr   (lo_wr),
        .lo_data (lo_data),
        .e_q     (e_q),
        .lo_q    (lo_q)
    );

    // Accumulator and carry commit only for executed instructions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cy_q  <= 1'b0;
        end else if (commit) begin
            acc_q <= acc_nx;
            cy_q  <= cy_nx;
        end
    end

    // Output mapping.
    always_comb begin
        acc   = acc_q;
        carry = cy_q;
    end

endmodule

// File: rtl/acc4_exec_chk.sv
// Module: acc4_exec_chk
// Property checker bound to acc4_exec_unit. Observes ports and the
// load-run flag; drives nothing.
module acc4_exec_chk #(
    parameter int DW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [3:0]    op_code,
    input logic [DW-1:0] imm,
    input logic [DW-1:0] mem_data,
    input logic [DW-1:0] acc,
    input logic          carry,
    input logic          skip_req,
    input logic          ldi_run_q
);

    logic run_op;
    always_comb run_op = op_valid && !skip_req;

    AST_LDI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        run_op && op_code == 4'd1 && !ldi_run_q |=> acc == $past(imm) && carry == $past(carry)) // R2
        else $error("AST_LDI_FIRST");

    AST_LDI_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == 4'd1 && ldi_run_q |=> $stable(acc) && $stable(carry)) // R3
        else $error("AST_LDI_REPEAT");

    AST_ADDM_KEEPS_CY: assert property (@(posedge clk) disable iff (!rst_n)
        run_op && op_code == 4'd2 |=> $stable(carry) && acc == DW'($past(acc) + $past(mem_data))) // R4
        else $error("AST_ADDM_KEEPS_CY");

    AST_SETC: assert property (@(posedge clk) disable iff (!rst_n)
        run_op && op_code == 4'd5 |=> carry && $stable(acc)) // R7
        else $error("AST_SETC");

    AST_TSTC_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        run_op && op_code == 4'd7 |=> skip_req == !$past(carry)) // R8
        else $error("AST_TSTC_SKIP");

    AST_DISCARD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && skip_req |=> $stable(acc) && $stable(carry) && !skip_req) // R13
        else $error("AST_DISCARD_HOLDS");

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(acc) && $stable(carry) && $stable(skip_req)) // R13
        else $error("AST_IDLE_HOLDS");

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> acc == '0 && !carry && !skip_req) // R1
        else $error("AST_RESET_CLEARS");

endmodule

bind acc4_exec_unit acc4_exec_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .imm       (imm),
    .mem_data  (mem_data),
    .acc       (acc),
    .carry     (carry),
    .skip_req  (skip_req),
    .ldi_run_q (ldi_run_q)
);

// File: tb/sim_acc4_exec_unit.sv
`timescale 1ns/1ps
module sim_acc4_exec_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic [3:0] imm = '0;
    logic [3:0] mem_data = '0;
    logic       e_wr = 1'b0;
    logic [3:0] e_data = '0;
    logic       lo_wr = 1'b0;
    logic [1:0] lo_data = '0;
    logic [3:0] acc;
    logic       carry;
    logic       skip_req;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Reference state.
    logic [3:0] m_a, m_e;
    logic       m_cy, m_skp, m_run;
    logic [1:0] m_lo;

    always #4 clk = ~clk;

    acc4_exec_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .imm(imm), .mem_data(mem_data), .e_wr(e_wr), .e_data(e_data),
        .lo_wr(lo_wr), .lo_data(lo_data), .acc(acc), .carry(carry),
        .skip_req(skip_req)
    );

    function automatic string tag_of(input logic [3:0] op, input bit disc, input bit val);
        if (!val) return "R13(idle)";
        if (disc && op == 4'd1) return "R3";
        if (disc) return "R13";
        case (op)
            4'd1: return "R2";
            4'd2: return "R4";
            4'd3: return "R5";
            4'd4: return "R6";
            4'd5, 4'd6: return "R7";
            4'd7: return "R8";
            4'd8: return "R9";
            4'd9: return "R10";
            4'd10: return "R11";
            default: return "R14";
        endcase
    endfunction

    function automatic logic [3:0] logic_ref(input logic [1:0] s, input logic [3:0] a, input logic [3:0] b);
        if (s == 2'b00) return a ^ b;
        if (s == 2'b01) return a | b;
        return a & b;
    endfunction

    task automatic check(input string tag);
        total++;
        if (acc !== m_a || carry !== m_cy || skip_req !== m_skp) begin
            bad++;
            $display("FAIL %s: acc=%0d carry=%0b skip=%0b expected acc=%0d carry=%0b skip=%0b",
                     tag, acc, carry, skip_req, m_a, m_cy, m_skp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        op_valid = 1'b0; e_wr = 1'b0; lo_wr = 1'b0;
        @(posedge clk); @(negedge clk);
        m_a = '0; m_cy = 0; m_e = '0; m_lo = '0; m_skp = 0; m_run = 0;
        check("R1");
        rst_n = 1'b1;
    endtask

    // One cycle: drive at falling edge, check at the next falling edge.
    task automatic step(input bit v, input logic [3:0] op, input logic [3:0] im,
                        input logic [3:0] md, input bit ew, input logic [3:0] ed,
                        input bit lw, input logic [1:0] ld, input string force_tag = "");
        bit disc;
        logic [4:0] s;
        bit sk;
        string t;
        op_valid = v; op_code = op; imm = im; mem_data = md;
        e_wr = ew; e_data = ed; lo_wr = lw; lo_data = ld;
        disc = m_skp || (op == 4'd1 && m_run);
        t = (force_tag != "") ? force_tag : tag_of(op, disc, v);
        if (v) begin
            sk = 0;
            if (!disc) begin
                case (op)
                    4'd1: m_a = im;
                    4'd2: m_a = m_a + md;
                    4'd3: begin s = m_a + md + m_cy; m_a = s[3:0]; m_cy = s[4]; end
                    4'd4: begin s = m_a + im; m_a = s[3:0]; sk = !s[4]; end
                    4'd5: m_cy = 1;
                    4'd6: m_cy = 0;
                    4'd7: sk = !m_cy;
                    4'd8: m_a = ~m_a;
                    4'd9: begin s = {m_a[0], m_cy, m_a[3:1]}; m_a = s[3:0]; m_cy = s[4]; end
                    4'd10: m_a = logic_ref(m_lo, m_a, m_e);
                    default: ;
                endcase
            end
            m_skp = sk;
            m_run = (op == 4'd1);
        end
        if (ew) m_e = ed;
        if (lw) m_lo = ld;
        @(posedge clk); @(negedge clk);
        op_valid = 1'b0; e_wr = 1'b0; lo_wr = 1'b0;
        check(t);
    endtask

    task automatic op1(input logic [3:0] op, input logic [3:0] im = 0, input logic [3:0] md = 0);
        step(1, op, im, md, 0, 0, 0, 0);
    endtask

    // Watchdog.
    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: expired, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R2/R3: load run, broken only by idle cycles
        op1(4'd1, 4'd5);
        op1(4'd1, 4'd9);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        op1(4'd1, 4'd12);
        op1(4'd0);
        op1(4'd1, 4'd12);
        // R5: add with carry overflow
        op1(4'd3, 0, 4'd7);
        op1(4'd3, 0, 4'd0);
        // R7 then R4: carry kept by plain add with overflow
        op1(4'd5);
        op1(4'd2, 0, 4'd15);
        op1(4'd6);
        op1(4'd2, 0, 4'd15);
        // R6: overflow -> no skip; no overflow -> skip and discard next
        op1(4'd1, 4'd15);
        op1(4'd4, 4'd1);
        op1(4'd4, 4'd2);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        op1(4'd8);
        op1(4'd8);
        // R8: carry-zero test both ways
        op1(4'd6);
        op1(4'd7);
        op1(4'd5);
        op1(4'd5);
        op1(4'd7);
        // R3/R13: discarded load still starts a run
        op1(4'd6);
        op1(4'd7);
        op1(4'd1, 4'd3);
        op1(4'd1, 4'd4);
        // R9, R10
        op1(4'd8);
        op1(4'd5);
        op1(4'd9);
        op1(4'd9);
        // R12: E/LO writes, also during a discard
        step(0, 0, 0, 0, 1, 4'b0110, 1, 2'b00, "R12");
        op1(4'd1, 4'b1010);
        for (int k = 0; k < 4; k++) begin
            step(0, 0, 0, 0, 0, 0, 1, k[1:0], "R12");
            op1(4'd10);
            op1(4'd0);
            op1(4'd1, 4'b1010);
        end
        op1(4'd6);
        op1(4'd7);
        step(1, 4'd10, 0, 0, 1, 4'b1111, 1, 2'b01, "R12");
        op1(4'd10);
        // R14: unused opcodes
        for (int k = 11; k < 16; k++) op1(k[3:0], 4'd7, 4'd9);
        // R1: reset mid-run with pending skip
        op1(4'd1, 4'd0);
        op1(4'd0);
        op1(4'd4, 4'd1);
        do_reset();
        // Random mix
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [3:0] op;
            r = $urandom_range(0, 19);
            if (r < 4) op = 4'd1;
            else if (r < 7) op = 4'd4;
            else op = 4'($urandom_range(0, 15));
            step($urandom_range(0, 4) != 0, op, 4'($urandom), 4'($urandom),
                 $urandom_range(0, 5) == 0, 4'($urandom),
                 $urandom_range(0, 5) == 0, 2'($urandom));
            if ($urandom_range(0, 499) == 0) do_reset();
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule